// File: doc/BRIEF.md
# Per-Endpoint Error Freeze Controller

This block holds the isolation state for a configurable set of partitionable endpoints (up to 16 by default). Each endpoint carries four bits of state: a flag that stops memory-mapped loads and stores, a flag that stops DMA traffic, an isolation-enable bit and an endpoint reset bit. When a failure event arrives tagged with an endpoint index, that endpoint and every endpoint below it in the hierarchy are frozen. The hierarchy is described by a parent map supplied on the ports.

The controller sits in the request paths of a host bridge. Outbound loads and stores are forwarded only to endpoints that are not MMIO-stopped. A load to a stopped endpoint returns all-ones data. Inbound DMA requests and MSIs are forwarded only from endpoints that are not DMA-stopped. Completions of DMA requests already issued do not pass through this filter, so they may still finish.

Software uses a command port to clear each stopped state separately, to drive endpoint reset, and to enable or disable isolation. A separate status port reads any endpoint's state. Both ports stay usable while endpoints are frozen.

Top module: `pe_freeze_ctrl`

## Requirements
- R1: A failure event on endpoint `p` sets both the MMIO-stopped and the DMA-stopped flag of `p`. The new flags are visible on the status port from the next cycle.
- R2: A load to an endpoint whose MMIO path is blocked is not forwarded. It returns all-ones on `mmio_rdata_o`. A store to such an endpoint is not forwarded. An endpoint's MMIO path is blocked while its MMIO-stopped flag is set, and also in the same cycle that a failure event hits it.
- R3: A blocked load to an endpoint whose isolation is disabled raises `mmio_mchk_o` in that cycle. With isolation enabled, a blocked load does not raise it. Neither stores nor forwarded loads ever raise it.
- R4: A DMA request or MSI from an endpoint whose DMA path is blocked is not forwarded. The DMA path is blocked while the DMA-stopped flag is set, and also in the cycle that a failure event hits the endpoint.
- R5: Command code 2 clears only the MMIO-stopped flag of the addressed endpoint. Command code 3 clears only its DMA-stopped flag. No other endpoint changes.
- R6: Command code 1 asserts the addressed endpoint's reset on `pe_rst_o`. Command code 4 deasserts that reset and clears both of the endpoint's stopped flags.
- R7: A failure event on endpoint `p` also freezes every endpoint whose chain of parents reaches `p`. Endpoint `j` has a parent only when `has_parent_i[j]` is 1; that parent is `parent_i[j*IDX_W +: IDX_W]`. Endpoints outside this subtree keep their state.
- R8: After reset, every endpoint has isolation enabled, both stopped flags clear and reset deasserted.
- R9: `stat_o` shows the state of endpoint `stat_pe_i` in the same cycle. Bit 0 is MMIO-stopped, bit 1 is DMA-stopped, bit 2 is reset and bit 3 is isolation-enable. Commands take effect regardless of any freeze.
- R10: When a failure event and a command hit the same endpoint in the same cycle, both stopped flags end set.
- R11: Command code 6 disables isolation for the addressed endpoint and command code 5 enables it. Codes 0 and 7 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| fail_valid_i | input | 1 | Failure event strobe |
| fail_pe_i | input | IDX_W | Endpoint where the failure was detected |
| parent_i | input | NUM_PE*IDX_W | Parent index of each endpoint, packed by endpoint |
| has_parent_i | input | NUM_PE | Endpoint has a parent in the map |
| mmio_valid_i | input | 1 | Outbound load/store present |
| mmio_write_i | input | 1 | 1 = store, 0 = load |
| mmio_pe_i | input | IDX_W | Target endpoint of the load/store |
| mmio_fwd_o | output | 1 | Load/store forwarded to the endpoint |
| ep_rdata_i | input | DATA_W | Load data returned by the endpoint side |
| mmio_rdata_o | output | DATA_W | Load data delivered to the processor |
| mmio_mchk_o | output | 1 | Machine-check indication for a blocked load |
| dma_valid_i | input | 1 | Inbound DMA request or MSI present |
| dma_pe_i | input | IDX_W | Source endpoint of the DMA request or MSI |
| dma_fwd_o | output | 1 | DMA request or MSI forwarded to the host |
| cmd_valid_i | input | 1 | Software command strobe |
| cmd_pe_i | input | IDX_W | Endpoint the command addresses |
| cmd_i | input | 3 | Command code |
| stat_pe_i | input | IDX_W | Endpoint selected for status read |
| stat_o | output | 4 | Status of the selected endpoint |
| pe_rst_o | output | NUM_PE | Reset drive for each endpoint |

## Verification
The assertions assume that endpoint indices on all ports are below NUM_PE. They also assume that the parent map does not change in a cycle that carries a failure event, and that no failure event is raised while reset is asserted. The stimulus keeps one fixed, acyclic parent map throughout. It draws every index from the valid range and holds all strobes low during reset. The randomised phase draws command codes from the full 3-bit range, so the unused codes are also exercised under these assumptions.

// File: rtl/pe_freeze_pkg.sv
package pe_freeze_pkg;
  typedef enum logic [2:0] {
    CMD_NOP      = 3'd0,
    CMD_RST_ON   = 3'd1,
    CMD_REL_MMIO = 3'd2,
    CMD_REL_DMA  = 3'd3,
    CMD_RST_OFF  = 3'd4,
    CMD_ISO_ON   = 3'd5,
    CMD_ISO_OFF  = 3'd6
  } pe_cmd_e;

  typedef struct packed {
    logic iso_en;
    logic in_rst;
    logic dma_stop;
    logic mmio_stop;
  } pe_status_t;
endpackage

// File: rtl/pe_fail_spread.sv
module pe_fail_spread #(
  parameter int NUM_PE = 16,
  parameter int IDX_W  = 4
) (
  input  logic                    fail_valid_i,
  input  logic [IDX_W-1:0]        fail_pe_i,
  input  logic [NUM_PE*IDX_W-1:0] parent_i,
  input  logic [NUM_PE-1:0]       has_parent_i,
  output logic [NUM_PE-1:0]       hit_o
);
  logic [NUM_PE-1:0] par_oh [NUM_PE];
  logic [NUM_PE-1:0] lvl    [NUM_PE];

  for (genvar j = 0; j < NUM_PE; j++) begin : g_map
    for (genvar p = 0; p < NUM_PE; p++) begin : g_par
      assign par_oh[j][p] = has_parent_i[j] &&
                            (parent_i[j*IDX_W +: IDX_W] == IDX_W'(p));
    end
    assign lvl[0][j] = fail_valid_i && (fail_pe_i == IDX_W'(j));
  end

  // one hop per stage; NUM_PE-1 hops cover the deepest chain
  for (genvar s = 1; s < NUM_PE; s++) begin : g_hop
    for (genvar j = 0; j < NUM_PE; j++) begin : g_pe
      assign lvl[s][j] = lvl[s-1][j] | (|(par_oh[j] & lvl[s-1]));
    end
  end

  assign hit_o = lvl[NUM_PE-1];
endmodule

// File: rtl/pe_state_bank.sv
module pe_state_bank
  import pe_freeze_pkg::*;
#(
  parameter int NUM_PE = 16,
  parameter int IDX_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_PE-1:0] hit_i,
  input  logic              cmd_valid_i,
  input  logic [IDX_W-1:0]  cmd_pe_i,
  input  pe_cmd_e           cmd_i,
  output logic [NUM_PE-1:0] mmio_stop_o,
  output logic [NUM_PE-1:0] dma_stop_o,
  output logic [NUM_PE-1:0] iso_en_o,
  output logic [NUM_PE-1:0] in_rst_o
);
  for (genvar k = 0; k < NUM_PE; k++) begin : g_pe
    logic sel;
    assign sel = cmd_valid_i && (cmd_pe_i == IDX_W'(k));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        mmio_stop_o[k] <= 1'b0;
        dma_stop_o[k]  <= 1'b0;
        iso_en_o[k]    <= 1'b1;
        in_rst_o[k]    <= 1'b0;
      end else begin
        if (sel) begin
          case (cmd_i)
            CMD_RST_ON:   in_rst_o[k] <= 1'b1;
            CMD_RST_OFF: begin
              in_rst_o[k]    <= 1'b0;
              mmio_stop_o[k] <= 1'b0;
              dma_stop_o[k]  <= 1'b0;
            end
            CMD_REL_MMIO: mmio_stop_o[k] <= 1'b0;
            CMD_REL_DMA:  dma_stop_o[k]  <= 1'b0;
            CMD_ISO_ON:   iso_en_o[k]    <= 1'b1;
            CMD_ISO_OFF:  iso_en_o[k]    <= 1'b0;
            default: ;
          endcase
        end
        // failure overrides any same-cycle release
        if (hit_i[k]) begin
          mmio_stop_o[k] <= 1'b1;
          dma_stop_o[k]  <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/pe_access_filter.sv
module pe_access_filter #(
  parameter int NUM_PE = 16,
  parameter int IDX_W  = 4,
  parameter int DATA_W = 32
) (
  input  logic              mmio_valid_i,
  input  logic              mmio_write_i,
  input  logic [IDX_W-1:0]  mmio_pe_i,
  input  logic [DATA_W-1:0] ep_rdata_i,
  input  logic              dma_valid_i,
  input  logic [IDX_W-1:0]  dma_pe_i,
  input  logic [NUM_PE-1:0] mmio_blk_i,
  input  logic [NUM_PE-1:0] dma_blk_i,
  input  logic [NUM_PE-1:0] iso_en_i,
  output logic              mmio_fwd_o,
  output logic [DATA_W-1:0] mmio_rdata_o,
  output logic              mmio_mchk_o,
  output logic              dma_fwd_o
);
  logic [NUM_PE-1:0] m_sel, d_sel;
  logic m_blk, m_iso, d_blk, load_hit;

  for (genvar k = 0; k < NUM_PE; k++) begin : g_sel
    assign m_sel[k] = (mmio_pe_i == IDX_W'(k));
    assign d_sel[k] = (dma_pe_i  == IDX_W'(k));
  end

  assign m_blk    = |(mmio_blk_i & m_sel);
  assign m_iso    = |(iso_en_i & m_sel);
  assign d_blk    = |(dma_blk_i & d_sel);
  assign load_hit = mmio_valid_i && !mmio_write_i && m_blk;

  assign mmio_fwd_o   = mmio_valid_i && !m_blk;
  assign mmio_rdata_o = load_hit ? {DATA_W{1'b1}} : ep_rdata_i;
  assign mmio_mchk_o  = load_hit && !m_iso;
  assign dma_fwd_o    = dma_valid_i && !d_blk;
endmodule

// File: rtl/pe_freeze_ctrl.sv
module pe_freeze_ctrl
  import pe_freeze_pkg::*;
#(
  parameter int  NUM_PE = 16,
  parameter int  DATA_W = 32,
  localparam int IDX_W  = (NUM_PE > 1) ? $clog2(NUM_PE) : 1
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    fail_valid_i,
  input  logic [IDX_W-1:0]        fail_pe_i,
  input  logic [NUM_PE*IDX_W-1:0] parent_i,
  input  logic [NUM_PE-1:0]       has_parent_i,
  input  logic                    mmio_valid_i,
  input  logic                    mmio_write_i,
  input  logic [IDX_W-1:0]        mmio_pe_i,
  output logic                    mmio_fwd_o,
  input  logic [DATA_W-1:0]       ep_rdata_i,
  output logic [DATA_W-1:0]       mmio_rdata_o,
  output logic                    mmio_mchk_o,
  input  logic                    dma_valid_i,
  input  logic [IDX_W-1:0]        dma_pe_i,
  output logic                    dma_fwd_o,
  input  logic                    cmd_valid_i,
  input  logic [IDX_W-1:0]        cmd_pe_i,
  input  logic [2:0]              cmd_i,
  input  logic [IDX_W-1:0]        stat_pe_i,
  output logic [3:0]              stat_o,
  output logic [NUM_PE-1:0]       pe_rst_o
);
  logic [NUM_PE-1:0] fail_hit;
  logic [NUM_PE-1:0] mmio_stop_q, dma_stop_q, iso_en_q, rst_q;
  logic [NUM_PE-1:0] s_sel;
  pe_status_t        stat;

  pe_fail_spread #(.NUM_PE(NUM_PE), .IDX_W(IDX_W)) u_spread (
    .fail_valid_i (fail_valid_i),
    .fail_pe_i    (fail_pe_i),
    .parent_i     (parent_i),
    .has_parent_i (has_parent_i),
    .hit_o        (fail_hit)
  );

  pe_state_bank #(.NUM_PE(NUM_PE), .IDX_W(IDX_W)) u_bank (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .hit_i       (fail_hit),
    .cmd_valid_i (cmd_valid_i),
    .cmd_pe_i    (cmd_pe_i),
    .cmd_i       (pe_cmd_e'(cmd_i)),
    .mmio_stop_o (mmio_stop_q),
    .dma_stop_o  (dma_stop_q),
    .iso_en_o    (iso_en_q),
    .in_rst_o    (rst_q)
  );

  // same-cycle failure blocks the triggering access too
  pe_access_filter #(.NUM_PE(NUM_PE), .IDX_W(IDX_W), .DATA_W(DATA_W)) u_filter (
    .mmio_valid_i (mmio_valid_i),
    .mmio_write_i (mmio_write_i),
    .mmio_pe_i    (mmio_pe_i),
    .ep_rdata_i   (ep_rdata_i),
    .dma_valid_i  (dma_valid_i),
    .dma_pe_i     (dma_pe_i),
    .mmio_blk_i   (mmio_stop_q | fail_hit),
    .dma_blk_i    (dma_stop_q | fail_hit),
    .iso_en_i     (iso_en_q),
    .mmio_fwd_o   (mmio_fwd_o),
    .mmio_rdata_o (mmio_rdata_o),
    .mmio_mchk_o  (mmio_mchk_o),
    .dma_fwd_o    (dma_fwd_o)
  );

  for (genvar k = 0; k < NUM_PE; k++) begin : g_stat
    assign s_sel[k] = (stat_pe_i == IDX_W'(k));
  end

  assign stat.iso_en    = |(iso_en_q & s_sel);
  assign stat.in_rst    = |(rst_q & s_sel);
  assign stat.dma_stop  = |(dma_stop_q & s_sel);
  assign stat.mmio_stop = |(mmio_stop_q & s_sel);
  assign stat_o   = stat;
  assign pe_rst_o = rst_q;
endmodule

// File: rtl/pe_freeze_ctrl_chk.sv
module pe_freeze_ctrl_chk #(
  parameter int NUM_PE = 16,
  parameter int IDX_W  = 4,
  parameter int DATA_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              mmio_valid_i,
  input logic              mmio_write_i,
  input logic [IDX_W-1:0]  mmio_pe_i,
  input logic              mmio_fwd_o,
  input logic [DATA_W-1:0] mmio_rdata_o,
  input logic              mmio_mchk_o,
  input logic              dma_valid_i,
  input logic [IDX_W-1:0]  dma_pe_i,
  input logic              dma_fwd_o,
  input logic [NUM_PE-1:0] fail_hit,
  input logic [NUM_PE-1:0] mmio_stop_q,
  input logic [NUM_PE-1:0] dma_stop_q,
  input logic [NUM_PE-1:0] iso_en_q
);
  AST_MCHK_ON_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mmio_mchk_o |-> (mmio_valid_i && !mmio_write_i && !mmio_fwd_o)); // R3

  for (genvar k = 0; k < NUM_PE; k++) begin : g_pe
    AST_FAIL_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      fail_hit[k] |=> (mmio_stop_q[k] && dma_stop_q[k])); // R10

    AST_STOP_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(mmio_stop_q[k]) |-> $past(fail_hit[k])); // R7

    AST_LOAD_ONES: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mmio_valid_i && !mmio_write_i && mmio_pe_i == IDX_W'(k) && mmio_stop_q[k])
      |-> (mmio_rdata_o == {DATA_W{1'b1}} && !mmio_fwd_o)); // R2

    AST_STORE_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mmio_valid_i && mmio_write_i && mmio_pe_i == IDX_W'(k) && mmio_stop_q[k])
      |-> !mmio_fwd_o); // R2

    AST_MCHK_ISO_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mmio_mchk_o && mmio_pe_i == IDX_W'(k)) |-> !iso_en_q[k]); // R3

    AST_DMA_BLOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (dma_valid_i && dma_pe_i == IDX_W'(k) && dma_stop_q[k]) |-> !dma_fwd_o); // R4
  end
endmodule

bind pe_freeze_ctrl pe_freeze_ctrl_chk #(
  .NUM_PE(NUM_PE), .IDX_W(IDX_W), .DATA_W(DATA_W)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .mmio_valid_i (mmio_valid_i),
  .mmio_write_i (mmio_write_i),
  .mmio_pe_i    (mmio_pe_i),
  .mmio_fwd_o   (mmio_fwd_o),
  .mmio_rdata_o (mmio_rdata_o),
  .mmio_mchk_o  (mmio_mchk_o),
  .dma_valid_i  (dma_valid_i),
  .dma_pe_i     (dma_pe_i),
  .dma_fwd_o    (dma_fwd_o),
  .fail_hit     (fail_hit),
  .mmio_stop_q  (mmio_stop_q),
  .dma_stop_q   (dma_stop_q),
  .iso_en_q     (iso_en_q)
);

// File: tb/pe_freeze_ctrl_bench.sv
module pe_freeze_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int N  = 16;
  localparam int IW = 4;
  localparam int DW = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fail_v = 1'b0;
  logic [IW-1:0] fail_pe = '0;
  logic [N*IW-1:0] parent = '0;
  logic [N-1:0] has_par = '0;
  logic mmio_v = 1'b0, mmio_wr = 1'b0;
  logic [IW-1:0] mmio_pe = '0;
  logic [DW-1:0] ep_rdata = '0;
  logic dma_v = 1'b0;
  logic [IW-1:0] dma_pe = '0;
  logic cmd_v = 1'b0;
  logic [IW-1:0] cmd_pe = '0;
  logic [2:0] cmd = '0;
  logic [IW-1:0] stat_pe = '0;
  logic mmio_fwd, mmio_mchk, dma_fwd;
  logic [DW-1:0] mmio_rdata;
  logic [3:0] stat;
  logic [N-1:0] pe_rst;

  int tests = 0;
  int fails = 0;
  int par_a [N];
  bit hp_a [N];
  bit m_mmio [N], m_dma [N], m_iso [N], m_rst [N];

  pe_freeze_ctrl #(.NUM_PE(N), .DATA_W(DW)) u_pe_freeze_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .fail_valid_i(fail_v), .fail_pe_i(fail_pe),
    .parent_i(parent), .has_parent_i(has_par), .mmio_valid_i(mmio_v),
    .mmio_write_i(mmio_wr), .mmio_pe_i(mmio_pe), .mmio_fwd_o(mmio_fwd),
    .ep_rdata_i(ep_rdata), .mmio_rdata_o(mmio_rdata), .mmio_mchk_o(mmio_mchk),
    .dma_valid_i(dma_v), .dma_pe_i(dma_pe), .dma_fwd_o(dma_fwd),
    .cmd_valid_i(cmd_v), .cmd_pe_i(cmd_pe), .cmd_i(cmd), .stat_pe_i(stat_pe),
    .stat_o(stat), .pe_rst_o(pe_rst)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic bit is_desc(int j, int f);
    int cur = j;
    for (int s = 0; s < N; s++) begin
      if (cur == f) return 1'b1;
      if (!hp_a[cur]) return 1'b0;
      cur = par_a[cur];
    end
    return 1'b0;
  endfunction

  // reference model: update on each active edge
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < N; k++) begin
        m_mmio[k] = 0; m_dma[k] = 0; m_iso[k] = 1; m_rst[k] = 0;
      end
    end else begin
      if (cmd_v) begin
        case (cmd)
          3'd1: m_rst[cmd_pe] = 1;
          3'd2: m_mmio[cmd_pe] = 0;
          3'd3: m_dma[cmd_pe] = 0;
          3'd4: begin m_rst[cmd_pe] = 0; m_mmio[cmd_pe] = 0; m_dma[cmd_pe] = 0; end
          3'd5: m_iso[cmd_pe] = 1;
          3'd6: m_iso[cmd_pe] = 0;
          default: ;
        endcase
      end
      if (fail_v)
        for (int k = 0; k < N; k++)
          if (is_desc(k, int'(fail_pe))) begin m_mmio[k] = 1; m_dma[k] = 1; end
    end
  end

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic compare_all();
    bit mb, db;
    logic [DW-1:0] erd;
    logic [N-1:0] erst;
    mb = m_mmio[mmio_pe] || (fail_v && is_desc(int'(mmio_pe), int'(fail_pe)));
    db = m_dma[dma_pe]   || (fail_v && is_desc(int'(dma_pe), int'(fail_pe)));
    erd = (mmio_v && !mmio_wr && mb) ? '1 : ep_rdata;
    for (int k = 0; k < N; k++) erst[k] = m_rst[k];
    chk(mmio_fwd == (mmio_v && !mb), "R2", "mmio_fwd", mmio_fwd, mmio_v && !mb);
    chk(mmio_rdata == erd, "R2", "mmio_rdata", mmio_rdata, erd);
    chk(mmio_mchk == (mmio_v && !mmio_wr && mb && !m_iso[mmio_pe]), "R3", "mchk",
        mmio_mchk, mmio_v && !mmio_wr && mb && !m_iso[mmio_pe]);
    chk(dma_fwd == (dma_v && !db), "R4", "dma_fwd", dma_fwd, dma_v && !db);
    chk(stat == {m_iso[stat_pe], m_rst[stat_pe], m_dma[stat_pe], m_mmio[stat_pe]},
        "R9", "stat", stat, {m_iso[stat_pe], m_rst[stat_pe], m_dma[stat_pe], m_mmio[stat_pe]});
    chk(pe_rst == erst, "R6", "pe_rst", pe_rst, erst);
  endtask

  task automatic idle();
    fail_v = 0; mmio_v = 0; dma_v = 0; cmd_v = 0;
  endtask

  // drive after the falling edge, compare before the next rising edge
  task automatic cycle();
    #1; compare_all();
    @(negedge clk);
    idle();
  endtask

  task automatic peek(int pe, logic [3:0] exp, string req);
    stat_pe = IW'(pe);
    #1;
    chk(stat == exp, req, "status", stat, exp);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    for (int k = 0; k < N; k++) begin par_a[k] = 0; hp_a[k] = 0; end
    par_a[1] = 0; hp_a[1] = 1;
    par_a[2] = 1; hp_a[2] = 1;
    par_a[3] = 0; hp_a[3] = 1;
    par_a[5] = 4; hp_a[5] = 1;
    for (int k = 0; k < N; k++) begin
      parent[k*IW +: IW] = IW'(par_a[k]);
      has_par[k] = hp_a[k];
    end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R8 reset state
    peek(0, 4'b1000, "R8");
    peek(15, 4'b1000, "R8");
    chk(pe_rst == '0, "R8", "pe_rst after reset", pe_rst, 0);

    mmio_v = 1; mmio_pe = 2; ep_rdata = 32'h1234_5678; cycle();

    // failure on pe1 with load to pe1 in the same cycle
    fail_v = 1; fail_pe = 1; mmio_v = 1; mmio_pe = 1; ep_rdata = 32'hA5A5_0000;
    dma_v = 1; dma_pe = 2;
    #1;
    chk(mmio_rdata == 32'hFFFF_FFFF, "R2", "same-cycle load data", mmio_rdata, 32'hFFFF_FFFF);
    chk(dma_fwd == 0, "R4", "same-cycle child DMA", dma_fwd, 0);
    cycle();
    peek(1, 4'b1011, "R1");
    peek(2, 4'b1011, "R7");
    peek(0, 4'b1000, "R7");
    peek(3, 4'b1000, "R7");

    mmio_v = 1; mmio_wr = 1; mmio_pe = 2; dma_v = 1; dma_pe = 2; cycle();
    mmio_wr = 0;
    cmd_v = 1; cmd_pe = 2; cmd = 3'd2; cycle();
    peek(2, 4'b1010, "R5");
    peek(1, 4'b1011, "R5");
    cmd_v = 1; cmd_pe = 1; cmd = 3'd3; cycle();
    peek(1, 4'b1001, "R5");

    cmd_v = 1; cmd_pe = 1; cmd = 3'd6; cycle();
    peek(1, 4'b0001, "R11");
    mmio_v = 1; mmio_pe = 1;
    #1; chk(mmio_mchk == 1, "R3", "mchk iso off", mmio_mchk, 1);
    cycle();
    cmd_v = 1; cmd_pe = 1; cmd = 3'd5; cycle();
    peek(1, 4'b1001, "R11");
    mmio_v = 1; mmio_pe = 1;
    #1; chk(mmio_mchk == 0, "R3", "mchk iso on", mmio_mchk, 0);
    cycle();

    cmd_v = 1; cmd_pe = 1; cmd = 3'd1; cycle();
    peek(1, 4'b1101, "R6");
    chk(pe_rst[1] == 1, "R6", "pe_rst[1]", pe_rst[1], 1);
    cmd_v = 1; cmd_pe = 1; cmd = 3'd7; cycle();
    peek(1, 4'b1101, "R11");
    cmd_v = 1; cmd_pe = 1; cmd = 3'd4; cycle();
    peek(1, 4'b1000, "R6");

    // R10 failure beats release on same endpoint
    cmd_v = 1; cmd_pe = 5; cmd = 3'd2; fail_v = 1; fail_pe = 5; cycle();
    peek(5, 4'b1011, "R10");
    cmd_v = 1; cmd_pe = 4; cmd = 3'd4; fail_v = 1; fail_pe = 4; cycle();
    peek(4, 4'b1011, "R10");
    peek(5, 4'b1011, "R7");

    fail_v = 1; fail_pe = 3; dma_v = 1; dma_pe = 3;
    #1; chk(dma_fwd == 0, "R4", "DMA in fail cycle", dma_fwd, 0);
    cycle();
    dma_v = 1; dma_pe = 0;
    #1; chk(dma_fwd == 1, "R4", "DMA unfrozen pe", dma_fwd, 1);
    cycle();

    for (int i = 0; i < 400; i++) begin
      fail_v  = ($urandom_range(0, 9) == 0);
      fail_pe = IW'($urandom_range(0, N-1));
      mmio_v  = $urandom_range(0, 1);
      mmio_wr = $urandom_range(0, 1);
      mmio_pe = IW'($urandom_range(0, N-1));
      ep_rdata = $urandom;
      dma_v   = $urandom_range(0, 1);
      dma_pe  = IW'($urandom_range(0, N-1));
      cmd_v   = $urandom_range(0, 1);
      cmd_pe  = IW'($urandom_range(0, N-1));
      cmd     = 3'($urandom_range(0, 7));
      stat_pe = IW'($urandom_range(0, N-1));
      cycle();
    end

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule